// File: doc/BRIEF.md
# Dual-Rail Case Steering Unit

This block steers one four-phase handshake to one of four output channels, picked by a two-bit selector that arrives in dual-rail form. Each selector bit travels on a true rail and a false rail. A bit is valid when exactly one of its rails is high, and it is spacer when both rails are low. The block acts only when every selector bit is valid. It then raises the request of the channel whose index equals the selector value and acknowledges the selector once that channel acknowledges.

When the selector returns to spacer, the block withdraws the channel request. It releases its own acknowledge only after the channel's acknowledge has fallen, which closes both handshakes in return-to-zero order. The block runs from a clock: it samples the rails and the channel acknowledges on rising edges and changes state only there. A selector bit with both rails high is an illegal code. The block reports it on an error flag and starts no handshake.

Top module: `dr_case_steer`

## Requirements
- R1: While reset (active low) is asserted, and immediately after it, every `outReq` bit, `selAck` and `codeErr` are low.
- R2: Bit i of the selector reads as 1 when `selTrue[i]`=1 and `selFalse[i]`=0, as 0 when `selTrue[i]`=0 and `selFalse[i]`=1, and as spacer when both rails are 0. The selector value is bit1*2+bit0. After the first rising edge at which both bits are valid, `outReq[value]` is high and every other request is low.
- R3: After the first rising edge at which the selected channel's `outAck` is sampled high while its request is high, `selAck` is high.
- R4: After the first rising edge at which the acknowledged selector is sampled as all-spacer, the selected request is low and `selAck` stays high.
- R5: After the first rising edge in that return phase at which the selected channel's `outAck` is sampled low, `selAck` is low and the block accepts a new selector.
- R6: While only some selector bits are valid and the rest are spacer, no request rises and `selAck` stays low.
- R7: At most one `outReq` bit is high at any time. The index is held for the whole handshake, so a change on the selector rails after capture does not move the request.
- R8: An acknowledge on any channel other than the selected one does not advance the handshake.
- R9: If, while idle, any selector bit has both rails high at a rising edge, `codeErr` is high after that edge, with no request and no `selAck`. It clears after the first edge at which the selector is all-spacer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| selTrue | input | SEL_BITS | True rail of each selector bit |
| selFalse | input | SEL_BITS | False rail of each selector bit |
| selAck | output | 1 | Acknowledge of the selector channel |
| outReq | output | NUM_OUT | Request of each output channel |
| outAck | input | NUM_OUT | Acknowledge of each output channel |
| codeErr | output | 1 | Illegal selector code seen, held until spacer |

## Verification
A corrupted captured index shows up at the ports as a request on the wrong channel in the first cycle of the handshake. If the corruption happens later, it shows up as a handshake that stalls because the wrong acknowledge is watched. A wrong phase state shows as `selAck` rising before the channel acknowledges, or as the request and `selAck` falling in the wrong order. Each of these is visible within one clock of the edge that produced it. The behavioural model is compared at every clock, so the divergence is flagged in that same cycle.

// File: rtl/dr_case_pkg.sv
package dr_case_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_HELD,
    ST_RTZ,
    ST_FAULT
  } caseState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic driveReq;
    logic driveAck;
    logic raiseErr;
  } steerStrobe_t;

endpackage

// File: rtl/dr_case_ctrl.sv
module dr_case_ctrl
  import dr_case_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         selValid,
  input  logic         selSpacer,
  input  logic         selIllegal,
  input  logic         pickedAck,
  output steerStrobe_t strobe
);

  caseState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (selIllegal)    stateD = ST_FAULT;
        else if (selValid) stateD = ST_ISSUE;
      end
      ST_ISSUE: if (pickedAck)  stateD = ST_HELD;
      ST_HELD:  if (selSpacer)  stateD = ST_RTZ;
      ST_RTZ:   if (!pickedAck) stateD = ST_IDLE;
      ST_FAULT: if (selSpacer)  stateD = ST_IDLE;
      default:                  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.capture  = (stateQ == ST_IDLE) && selValid && !selIllegal;
    strobe.driveReq = (stateQ == ST_ISSUE) || (stateQ == ST_HELD);
    strobe.driveAck = (stateQ == ST_HELD) || (stateQ == ST_RTZ);
    strobe.raiseErr = (stateQ == ST_FAULT);
  end

endmodule

// File: rtl/dr_case_path.sv
module dr_case_path
  import dr_case_pkg::*;
#(
  parameter  int SEL_BITS = 2,
  localparam int NUM_OUT  = 1 << SEL_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_BITS-1:0] selTrue,
  input  logic [SEL_BITS-1:0] selFalse,
  input  logic [NUM_OUT-1:0]  outAck,
  input  steerStrobe_t        strobe,
  output logic                selValid,
  output logic                selSpacer,
  output logic                selIllegal,
  output logic                pickedAck,
  output logic [NUM_OUT-1:0]  outReq,
  output logic                selAck,
  output logic                codeErr
);

  logic [SEL_BITS-1:0] bitValid;
  logic [SEL_BITS-1:0] bitBad;
  logic [SEL_BITS-1:0] bitIdle;
  logic [SEL_BITS-1:0] idxQ;

  for (genvar b = 0; b < SEL_BITS; b++) begin : g_bit
    assign bitValid[b] = selTrue[b] ^ selFalse[b];
    assign bitBad[b]   = selTrue[b] & selFalse[b];
    assign bitIdle[b]  = ~(selTrue[b] | selFalse[b]);
  end

  assign selValid   = &bitValid;
  assign selIllegal = |bitBad;
  assign selSpacer  = &bitIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idxQ <= '0;
    else if (strobe.capture) idxQ <= selTrue;
  end

  assign pickedAck = outAck[idxQ];

  for (genvar c = 0; c < NUM_OUT; c++) begin : g_chan
    assign outReq[c] = strobe.driveReq && (idxQ == SEL_BITS'(c));
  end

  assign selAck  = strobe.driveAck;
  assign codeErr = strobe.raiseErr;

endmodule

// File: rtl/dr_case_steer.sv
module dr_case_steer
  import dr_case_pkg::*;
#(
  parameter  int SEL_BITS = 2,
  localparam int NUM_OUT  = 1 << SEL_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_BITS-1:0] selTrue,
  input  logic [SEL_BITS-1:0] selFalse,
  output logic                selAck,
  output logic [NUM_OUT-1:0]  outReq,
  input  logic [NUM_OUT-1:0]  outAck,
  output logic                codeErr
);

  steerStrobe_t strobe;
  logic selValid, selSpacer, selIllegal, pickedAck;

  dr_case_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selValid   (selValid),
    .selSpacer  (selSpacer),
    .selIllegal (selIllegal),
    .pickedAck  (pickedAck),
    .strobe     (strobe)
  );

  dr_case_path #(.SEL_BITS(SEL_BITS)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .selTrue    (selTrue),
    .selFalse   (selFalse),
    .outAck     (outAck),
    .strobe     (strobe),
    .selValid   (selValid),
    .selSpacer  (selSpacer),
    .selIllegal (selIllegal),
    .pickedAck  (pickedAck),
    .outReq     (outReq),
    .selAck     (selAck),
    .codeErr    (codeErr)
  );

endmodule

// File: rtl/dr_case_steer_chk.sv
module dr_case_steer_chk #(
  parameter  int SEL_BITS = 2,
  localparam int NUM_OUT  = 1 << SEL_BITS
) (
  input logic                clk,
  input logic                rstN,
  input logic [SEL_BITS-1:0] selTrue,
  input logic [SEL_BITS-1:0] selFalse,
  input logic                selAck,
  input logic [NUM_OUT-1:0]  outReq,
  input logic [NUM_OUT-1:0]  outAck,
  input logic                codeErr
);

  // R1: quiet outputs while in reset
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (outReq == '0 && !selAck && !codeErr);
    end
  end

  p_onehot_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outReq));

  p_req_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|outReq && |$past(outReq)) |-> (outReq == $past(outReq)));

  p_ack_after_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selAck) |-> |outReq);

  p_req_drop_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|outReq) |-> selAck);

  p_ack_drop_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selAck) |-> (outReq == '0));

  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> (outReq == '0 && !selAck));

endmodule

bind dr_case_steer dr_case_steer_chk #(.SEL_BITS(SEL_BITS)) u_chk (.*);

// File: tb/test_dr_case_steer.sv
module test_dr_case_steer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] selTrue = 2'b00;
  logic [1:0] selFalse = 2'b00;
  logic [3:0] respAck = 4'b0;
  logic [3:0] rogueAck = 4'b0;
  logic [3:0] outAck;
  logic       selAck;
  logic [3:0] outReq;
  logic       codeErr;

  int checks = 0;
  int errors = 0;
  bit respOn = 1'b1;
  bit finished = 1'b0;
  int ms = 0;     // model phase: 0 idle,1 issue,2 held,3 rtz,4 fault
  int midx = 0;

  assign outAck = respAck | rogueAck;

  always #5 clk = ~clk;

  dr_case_steer i_dr_case_steer (
    .clk      (clk),
    .rstN     (rstN),
    .selTrue  (selTrue),
    .selFalse (selFalse),
    .selAck   (selAck),
    .outReq   (outReq),
    .outAck   (outAck),
    .codeErr  (codeErr)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      ms = 0;
      midx = 0;
    end else begin
      bit anyBad, allOk, allZero;
      anyBad = 0; allOk = 1; allZero = 1;
      for (int b = 0; b < 2; b++) begin
        if (selTrue[b] && selFalse[b]) anyBad = 1;
        if (selTrue[b] == selFalse[b]) allOk = 0;
        if (selTrue[b] || selFalse[b]) allZero = 0;
      end
      case (ms)
        0: if (anyBad) ms = 4;
           else if (allOk) begin ms = 1; midx = 2 * selTrue[1] + selTrue[0]; end
        1: if (outAck[midx]) ms = 2;
        2: if (allZero) ms = 3;
        3: if (!outAck[midx]) ms = 0;
        4: if (allZero) ms = 0;
        default: ms = 0;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [3:0] eReq;
      eReq = (ms == 1 || ms == 2) ? 4'(1 << midx) : 4'b0;
      check(outReq == eReq, "R2 model outReq", 8'(outReq), 8'(eReq));
      check(selAck == (ms == 2 || ms == 3), "R3 model selAck", 8'(selAck), 8'(ms == 2 || ms == 3));
      check(codeErr == (ms == 4), "R9 model codeErr", 8'(codeErr), 8'(ms == 4));
    end
  end

  // channel responder: echoes each request one half-cycle later
  always @(negedge clk) respAck <= respOn ? outReq : 4'b0;

  task automatic driveSel(input int v);
    selTrue  = 2'(v);
    selFalse = ~2'(v);
  endtask

  task automatic driveSpacer();
    selTrue  = 2'b00;
    selFalse = 2'b00;
  endtask

  task automatic runOne(input int k);
    @(negedge clk); driveSel(k);
    @(negedge clk);
    check(outReq == 4'(1 << k), "R2 request on selected channel", 8'(outReq), 8'(1 << k));
    check(!selAck, "R3 no ack before channel ack", 8'(selAck), 8'd0);
    @(negedge clk);
    check(selAck, "R3 ack after channel ack", 8'(selAck), 8'd1);
    driveSpacer();
    @(negedge clk);
    check(outReq == 4'b0, "R4 request dropped on spacer", 8'(outReq), 8'd0);
    check(selAck, "R4 ack held through return", 8'(selAck), 8'd1);
    @(negedge clk);
    check(!selAck, "R5 ack released", 8'(selAck), 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outReq == 4'b0 && !selAck && !codeErr, "R1 reset state",
          {outReq, 2'b0, selAck, codeErr}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(outReq == 4'b0 && !selAck && !codeErr, "R1 after reset",
          {outReq, 2'b0, selAck, codeErr}, 8'd0);

    for (int k = 0; k < 4; k++) runOne(k);
    runOne(3);
    runOne(0);

    // R6: only bit0 valid, bit1 still spacer
    @(negedge clk); selTrue = 2'b01; selFalse = 2'b00;
    repeat (3) @(negedge clk);
    check(outReq == 4'b0 && !selAck, "R6 partial selector ignored", 8'(outReq), 8'd0);
    selFalse = 2'b10;   // value 1 complete
    @(negedge clk);
    check(outReq == 4'b0010, "R6 completed selector acts", 8'(outReq), 8'h02);
    @(negedge clk); driveSpacer();
    repeat (3) @(negedge clk);

    // R7: selector changes after capture
    respOn = 1'b0;
    @(negedge clk); driveSel(2);
    @(negedge clk); driveSel(1);
    repeat (3) @(negedge clk);
    check(outReq == 4'b0100, "R7 index held", 8'(outReq), 8'h04);
    check(!selAck, "R7 no ack while channel silent", 8'(selAck), 8'd0);

    // R8: foreign acknowledges do not advance
    rogueAck = 4'b1011;
    repeat (3) @(negedge clk);
    check(!selAck, "R8 foreign ack ignored", 8'(selAck), 8'd0);
    check(outReq == 4'b0100, "R8 request unchanged", 8'(outReq), 8'h04);
    rogueAck = 4'b0;
    respOn = 1'b1;
    repeat (2) @(negedge clk);
    check(selAck, "R8 own ack completes", 8'(selAck), 8'd1);
    driveSpacer();
    repeat (3) @(negedge clk);
    check(!selAck && outReq == 4'b0, "R5 back to idle", 8'(selAck), 8'd0);

    // R9: illegal code on bit0
    @(negedge clk); selTrue = 2'b01; selFalse = 2'b11;
    @(negedge clk);
    check(codeErr, "R9 error raised", 8'(codeErr), 8'd1);
    check(outReq == 4'b0 && !selAck, "R9 no activity", 8'(outReq), 8'd0);
    selTrue = 2'b10; selFalse = 2'b01;   // becomes legal but not spacer
    repeat (2) @(negedge clk);
    check(codeErr && outReq == 4'b0, "R9 error held until spacer", 8'(codeErr), 8'd1);
    driveSpacer();
    @(negedge clk);
    check(!codeErr, "R9 error cleared on spacer", 8'(codeErr), 8'd0);
    runOne(2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule